// File: doc/BRIEF.md
# Half-Duplex Shared-Line UART with Parity Refusal

This block is an asynchronous serial port for a single wire shared by both directions, as used with contact smart cards. The transmit output and the receive input are tied together outside the block. The line is wired-AND: any party may pull it low. A baud-rate generator runs from the system clock through a selectable prescaler. A transmitter with a one-byte holding buffer and a frame shift register sends start, eight data bits, even parity and one stop bit. A receiver oversamples the line sixteen times per bit and captures each frame into a receive buffer.

Parity errors are signalled in both directions on the wire. When the receiver finds that an incoming byte has bad parity, it pulls the line low for the whole stop-bit time. When the transmitter sends a frame, it samples the line in the middle of its own stop bit. A low level there means the far end refused the byte, and the transmitter records this in a sticky flag. The host side is a plain strobe-and-flag port: a write strobe with data, a read strobe with data, enables, status flags and two interrupt requests that are cleared by explicit clear strobes.

Top module: `sharedline_uart`

## Requirements
- R1: One bit lasts 16×(baudN+1)×D system clock cycles. D is 1 when divSel=0, 8 when divSel=1, and 32 when divSel is 2 or 3.
- R2: An idle line is high. A transmitted frame is, in order of time: a low start bit, data bits 0 to 7 (least significant first), an even parity bit (XOR of the eight data bits), and a high stop bit.
- R3: txBufEmpty goes low in the cycle after wrStrobe. The frame starts at the next bit boundary of the free-running baud divider, so the start bit begins within one bit period after the write. At that transfer txBufEmpty returns high and txRegEmpty goes low. txRegEmpty is high again once the stop bit has ended and no byte is pending.
- R4: With intCauseSel=1, irqTx is set when the shift register becomes empty with no byte pending. With intCauseSel=0, irqTx is set when a byte moves from the buffer into the shift register. irqTxClr clears irqTx; a set in the same cycle wins.
- R5: The receiver samples each bit at the 8th of its 16 sub-bit ticks, counted from the falling edge of the start bit. A start bit that is high again at mid-bit is dropped, and no frame is captured.
- R6: When a full frame has been received, rdData takes the byte, rxFull goes high and irqRx is set. rdStrobe clears rxFull and irqRxClr clears irqRx; a completing frame in the same cycle wins.
- R7: parityErr shows whether the last captured frame had bad even parity. For a bad frame the block drives lineOut low during that frame's stop-bit time. For a good frame lineOut stays high.
- R8: The transmitter samples the line at the middle of its stop bit. If the line is low, nackSeen is set and stays set until nackClr.
- R9: With txEnable low, no frame starts and a written byte waits in the buffer (txBufEmpty low, lineOut high). With rxEnable low, no frame is captured.
- R10: After reset: lineOut=1, txBufEmpty=1, txRegEmpty=1, rxFull=0, parityErr=0, nackSeen=0, irqTx=0, irqRx=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divSel | input | 2 | Prescaler select: 0 → /1, 1 → /8, 2 or 3 → /32 |
| baudN | input | BRG_W | Baud generator reload value n |
| txEnable | input | 1 | Allows frames to start |
| rxEnable | input | 1 | Allows start-bit detection |
| intCauseSel | input | 1 | 1: irqTx on shift register empty; 0: irqTx on buffer transfer |
| wrStrobe | input | 1 | Write wrData into the transmit buffer |
| wrData | input | DATA_W | Byte to send |
| rdStrobe | input | 1 | Read acknowledge; clears rxFull |
| rdData | output | DATA_W | Last received byte |
| nackClr | input | 1 | Clears nackSeen |
| irqTxClr | input | 1 | Clears irqTx |
| irqRxClr | input | 1 | Clears irqRx |
| lineIn | input | 1 | Shared line level, as read back |
| lineOut | output | 1 | Line drive (low pulls the wire low) |
| txBufEmpty | output | 1 | Transmit holding buffer is free |
| txRegEmpty | output | 1 | Transmit shift register is idle |
| rxFull | output | 1 | Receive buffer holds an unread byte |
| parityErr | output | 1 | Last captured frame had bad parity |
| nackSeen | output | 1 | Sticky: a stop bit was found pulled low |
| irqTx | output | 1 | Transmit interrupt request |
| irqRx | output | 1 | Receive interrupt request |

## Verification
The assertions assume that the host strobes are single-cycle pulses. They also assume that lineIn is the wired-AND of lineOut and the far end, so any low on the wire that the block did not drive comes from the other party. The bench keeps to this: it only ever drives a separate card line that is ANDed with lineOut. It changes divSel and baudN only while the transmitter is idle. It holds each far-end level for whole bit times, except for the deliberate short glitch used to test start-bit rejection.

// File: rtl/sharedline_uart_pkg.sv
package sharedline_uart_pkg;

  typedef enum logic {
    TX_IDLE,
    TX_SEND
  } txState_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_TAIL,
    RX_STOP
  } rxState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadTx;     // buffer -> shift register
    logic shiftTx;    // advance to next frame bit
    logic txEnd;      // stop bit finished
    logic stopProbe;  // sample line at stop-bit mid
    logic rxSample;   // shift one received bit in
    logic rxCommit;   // frame complete
    logic nackDrive;  // pull the line low (parity refusal)
  } ctrlStrobe_t;

endpackage

// File: rtl/sharedline_uart_baud.sv
module sharedline_uart_baud #(
  parameter int BRG_W = 8,
  parameter int OVS   = 16,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       divSel,
  input  logic [BRG_W-1:0] baudN,
  output logic             subTick,
  output logic             midTick,
  output logic             bitTick
);
  localparam int PRE_W = $clog2(DIV_C);
  localparam int OVS_W = $clog2(OVS);
  localparam int MID   = OVS / 2;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             srcTick;
  logic [BRG_W-1:0] brgCnt;
  logic [OVS_W-1:0] ovsCnt;

  always_comb begin
    unique case (divSel)
      2'd0:    preLimit = '0;
      2'd1:    preLimit = PRE_W'(DIV_B - 1);
      default: preLimit = PRE_W'(DIV_C - 1);
    endcase
  end

  assign srcTick = (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (srcTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brgCnt <= '0;
    end else if (srcTick) begin
      if (brgCnt == '0) brgCnt <= baudN;
      else              brgCnt <= brgCnt - 1'b1;
    end
  end

  assign subTick = srcTick && (brgCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovsCnt <= '0;
    end else if (subTick) begin
      if (ovsCnt == OVS_W'(OVS - 1)) ovsCnt <= '0;
      else                           ovsCnt <= ovsCnt + 1'b1;
    end
  end

  assign bitTick = subTick && (ovsCnt == OVS_W'(OVS - 1));
  assign midTick = subTick && (ovsCnt == OVS_W'(MID - 1));

endmodule

// File: rtl/sharedline_uart_ctrl.sv
module sharedline_uart_ctrl
  import sharedline_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        subTick,
  input  logic        midTick,
  input  logic        bitTick,
  input  logic        txEnable,
  input  logic        rxEnable,
  input  logic        txBufFull,
  input  logic        lineSync,
  input  logic        lineFall,
  input  logic        parityBad,
  output ctrlStrobe_t stb,
  output logic        txBusy
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int OVS_W      = $clog2(OVS);
  localparam int MID        = OVS / 2;

  txState_e         txState;
  logic [BIT_W-1:0] txIdx;
  rxState_e         rxState;
  logic [BIT_W-1:0] rxIdx;
  logic [OVS_W-1:0] rxSub;
  logic             rxMid;
  logic             rxWrap;
  logic             txLast;

  assign txLast = (txIdx == BIT_W'(FRAME_BITS - 1));
  assign rxMid  = subTick && (rxSub == OVS_W'(MID - 1));
  assign rxWrap = subTick && (rxSub == OVS_W'(OVS - 1));
  assign txBusy = (txState == TX_SEND);

  // strobe decode
  always_comb begin
    stb = '0;
    unique case (txState)
      TX_IDLE: begin
        if (bitTick && txEnable && txBufFull) stb.loadTx = 1'b1;
      end
      TX_SEND: begin
        if (bitTick) begin
          if (txLast) begin
            stb.txEnd = 1'b1;
            if (txEnable && txBufFull) stb.loadTx = 1'b1;
          end else begin
            stb.shiftTx = 1'b1;
          end
        end
        if (midTick && txLast) stb.stopProbe = 1'b1;
      end
      default: ;
    endcase

    unique case (rxState)
      RX_BITS:  stb.rxSample  = rxMid;
      RX_STOP: begin
        stb.nackDrive = parityBad;
        stb.rxCommit  = rxWrap;
      end
      default: ;
    endcase
  end

  // transmit sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: begin
          if (stb.loadTx) begin
            txState <= TX_SEND;
            txIdx   <= '0;
          end
        end
        TX_SEND: begin
          if (bitTick) begin
            if (txLast) begin
              txIdx <= '0;
              if (!stb.loadTx) txState <= TX_IDLE;
            end else begin
              txIdx <= txIdx + 1'b1;
            end
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState <= RX_IDLE;
      rxIdx   <= '0;
      rxSub   <= '0;
    end else begin
      if (rxState != RX_IDLE && subTick) begin
        if (rxSub == OVS_W'(OVS - 1)) rxSub <= '0;
        else                          rxSub <= rxSub + 1'b1;
      end
      unique case (rxState)
        RX_IDLE: begin
          if (rxEnable && lineFall) begin
            rxState <= RX_START;
            rxSub   <= '0;
          end
        end
        RX_START: begin
          if (rxMid) begin
            if (lineSync) rxState <= RX_IDLE;
            else begin
              rxState <= RX_BITS;
              rxIdx   <= '0;
            end
          end
        end
        RX_BITS: begin
          if (rxMid) begin
            if (rxIdx == BIT_W'(DATA_W)) rxState <= RX_TAIL;
            else                         rxIdx   <= rxIdx + 1'b1;
          end
        end
        RX_TAIL: begin
          if (rxWrap) rxState <= RX_STOP;
        end
        RX_STOP: begin
          if (rxWrap) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sharedline_uart_datapath.sv
module sharedline_uart_datapath
  import sharedline_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  logic              nackClr,
  input  logic              irqTxClr,
  input  logic              irqRxClr,
  input  logic              intCauseSel,
  input  logic              lineIn,
  output logic [DATA_W-1:0] rdData,
  output logic              txBufFull,
  output logic              lineSync,
  output logic              lineFall,
  output logic              parityBad,
  output logic              lineOut,
  output logic              rxFull,
  output logic              parityErr,
  output logic              nackSeen,
  output logic              irqTx,
  output logic              irqRx
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic [DATA_W-1:0]     txBuf;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W:0]       rxShift;
  logic                  lineMeta;
  logic                  linePrev;
  logic                  txIrqSet;

  // line synchroniser and edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineMeta <= 1'b1;
      lineSync <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      lineMeta <= lineIn;
      lineSync <= lineMeta;
      linePrev <= lineSync;
    end
  end
  assign lineFall = linePrev & ~lineSync;

  // transmit buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBuf     <= '0;
      txBufFull <= 1'b0;
    end else if (wrStrobe) begin
      txBuf     <= wrData;
      txBufFull <= 1'b1;
    end else if (stb.loadTx) begin
      txBufFull <= 1'b0;
    end
  end

  // frame shift register, LSB leaves first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '1;
    end else if (stb.loadTx) begin
      txShift <= {1'b1, ^txBuf, txBuf, 1'b0};
    end else if (stb.shiftTx) begin
      txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
    end else if (stb.txEnd) begin
      txShift <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lineOut <= 1'b1;
    else        lineOut <= txShift[0] & ~stb.nackDrive;
  end

  // refusal detection on own stop bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          nackSeen <= 1'b0;
    else if (stb.stopProbe && !lineSync) nackSeen <= 1'b1;
    else if (nackClr)                    nackSeen <= 1'b0;
  end

  // receive shift and buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (stb.rxSample) begin
      rxShift <= {lineSync, rxShift[DATA_W:1]};
    end
  end
  assign parityBad = ^rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData    <= '0;
      rxFull    <= 1'b0;
      parityErr <= 1'b0;
    end else if (stb.rxCommit) begin
      rdData    <= rxShift[DATA_W-1:0];
      rxFull    <= 1'b1;
      parityErr <= parityBad;
    end else if (rdStrobe) begin
      rxFull    <= 1'b0;
    end
  end

  // interrupt requests
  assign txIrqSet = intCauseSel ? (stb.txEnd && !stb.loadTx) : stb.loadTx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqTx <= 1'b0;
      irqRx <= 1'b0;
    end else begin
      if (txIrqSet)      irqTx <= 1'b1;
      else if (irqTxClr) irqTx <= 1'b0;
      if (stb.rxCommit)  irqRx <= 1'b1;
      else if (irqRxClr) irqRx <= 1'b0;
    end
  end

endmodule

// File: rtl/sharedline_uart.sv
module sharedline_uart
  import sharedline_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BRG_W  = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        divSel,
  input  logic [BRG_W-1:0]  baudN,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              intCauseSel,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  input  logic              nackClr,
  input  logic              irqTxClr,
  input  logic              irqRxClr,
  input  logic              lineIn,
  output logic              lineOut,
  output logic              txBufEmpty,
  output logic              txRegEmpty,
  output logic              rxFull,
  output logic              parityErr,
  output logic              nackSeen,
  output logic              irqTx,
  output logic              irqRx
);
  logic        subTick;
  logic        midTick;
  logic        bitTick;
  logic        txBufFull;
  logic        lineSync;
  logic        lineFall;
  logic        parityBad;
  logic        txBusy;
  ctrlStrobe_t stb;

  sharedline_uart_baud #(.BRG_W(BRG_W), .OVS(OVS)) baud_i (
    .clk, .rst_n, .divSel, .baudN,
    .subTick, .midTick, .bitTick
  );

  sharedline_uart_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) ctrl_i (
    .clk, .rst_n, .subTick, .midTick, .bitTick,
    .txEnable, .rxEnable, .txBufFull, .lineSync, .lineFall, .parityBad,
    .stb, .txBusy
  );

  sharedline_uart_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk, .rst_n, .stb, .wrStrobe, .wrData, .rdStrobe, .nackClr,
    .irqTxClr, .irqRxClr, .intCauseSel, .lineIn,
    .rdData, .txBufFull, .lineSync, .lineFall, .parityBad, .lineOut,
    .rxFull, .parityErr, .nackSeen, .irqTx, .irqRx
  );

  assign txBufEmpty = ~txBufFull;
  assign txRegEmpty = ~txBusy;

endmodule

// File: rtl/sharedline_uart_chk.sv
module sharedline_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic wrStrobe,
  input logic txBufEmpty,
  input logic txRegEmpty,
  input logic rdStrobe,
  input logic rxFull,
  input logic nackSeen,
  input logic nackClr,
  input logic irqTx,
  input logic irqTxClr,
  input logic irqRx,
  input logic irqRxClr,
  input logic lineOut,
  input logic loadTx,
  input logic txEnd,
  input logic stopProbe,
  input logic rxCommit,
  input logic nackDrive
);
  // R3
  buf_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> !txBufEmpty);

  // R6
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !rxCommit) |=> !rxFull);

  // R6
  rx_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqRxClr && !rxCommit) |=> !irqRx);

  // R4
  tx_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqTxClr && !loadTx && !txEnd) |=> !irqTx);

  // R8
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nackSeen && !nackClr) |=> nackSeen);

  // R8
  nack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nackSeen) |-> $past(stopProbe));

  // R7
  low_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lineOut |-> (!$past(txRegEmpty) || $past(nackDrive)));

endmodule

bind sharedline_uart sharedline_uart_chk chk_i (
  .clk, .rst_n, .wrStrobe, .txBufEmpty, .txRegEmpty, .rdStrobe, .rxFull,
  .nackSeen, .nackClr, .irqTx, .irqTxClr, .irqRx, .irqRxClr, .lineOut,
  .loadTx(stb.loadTx), .txEnd(stb.txEnd), .stopProbe(stb.stopProbe),
  .rxCommit(stb.rxCommit), .nackDrive(stb.nackDrive)
);

// File: tb/sharedline_uart_tb.sv
module sharedline_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic [7:0] baudN = 8'd3;
  logic       txEnable = 1'b1;
  logic       rxEnable = 1'b1;
  logic       intCauseSel = 1'b1;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       nackClr = 1'b0;
  logic       irqTxClr = 1'b0;
  logic       irqRxClr = 1'b0;
  logic       lineIn;
  logic       lineOut;
  logic       txBufEmpty, txRegEmpty, rxFull, parityErr, nackSeen, irqTx, irqRx;
  logic       cardLine = 1'b1;

  int total = 0;
  int bad = 0;
  int bitClk = 64;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign lineIn = lineOut & cardLine;

  sharedline_uart dut_i (
    .clk, .rst_n, .divSel, .baudN, .txEnable, .rxEnable, .intCauseSel,
    .wrStrobe, .wrData, .rdStrobe, .rdData, .nackClr, .irqTxClr, .irqRxClr,
    .lineIn, .lineOut, .txBufEmpty, .txRegEmpty, .rxFull, .parityErr,
    .nackSeen, .irqTx, .irqRx
  );

  // {badParity, data}
  localparam logic [8:0] VEC [6] = '{
    9'h000, 9'h1A5, 9'h03C, 9'h1FF, 9'h001, 9'h180
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrData = d; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic waitFlag(ref logic flag, input int limit);
    for (int i = 0; i < limit && flag !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic waitLow(input int limit, output int cycles);
    cycles = 0;
    while (lineOut !== 1'b0 && cycles < limit) begin @(negedge clk); cycles++; end
  endtask

  task automatic cardSend(input logic [7:0] d, input logic badPar, output logic stopMid);
    logic [10:0] fr;
    fr = {1'b1, (^d) ^ badPar, d, 1'b0};
    stopMid = 1'b1;
    for (int i = 0; i < 11; i++) begin
      cardLine = fr[i];
      if (i == 10) begin
        repeat (bitClk / 2) @(negedge clk);
        stopMid = lineOut;
        repeat (bitClk / 2) @(negedge clk);
      end else begin
        repeat (bitClk) @(negedge clk);
      end
    end
  endtask

  task automatic txCapture(input logic pullStop, output logic [10:0] fr);
    int c;
    waitLow(4000, c);
    repeat (bitClk / 2) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      fr[i] = lineOut;
      if (i == 9 && pullStop) begin
        repeat (bitClk / 2 + 8) @(negedge clk);
        cardLine = 1'b0;
        repeat (bitClk / 2 - 8) @(negedge clk);
      end else if (i < 10) begin
        repeat (bitClk) @(negedge clk);
      end
    end
    if (pullStop) begin
      repeat (16) @(negedge clk);
      cardLine = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [10:0] fr;
    logic stopMid;
    int c;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 lineOut", lineOut, 1);
    check("R10 txBufEmpty", txBufEmpty, 1);
    check("R10 txRegEmpty", txRegEmpty, 1);
    check("R10 flags", {rxFull, parityErr, nackSeen, irqTx, irqRx}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of far-end frames: R5 sampling, R6 capture, R7 parity refusal
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      logic b;
      d = VEC[v][7:0];
      b = VEC[v][8];
      cardSend(d, b, stopMid);
      check("R7 stop-bit drive", stopMid, !b);
      waitFlag(rxFull, 200);
      check("R6 rxFull", rxFull, 1);
      check("R6 rdData", rdData, d);
      check("R7 parityErr", parityErr, b);
      check("R6 irqRx", irqRx, 1);
      pulse(rdStrobe);
      check("R6 rxFull cleared", rxFull, 0);
      pulse(irqRxClr);
      check("R6 irqRx cleared", irqRx, 0);
      repeat (bitClk) @(negedge clk);
      check("R7 line released", lineOut, 1);
    end

    // R5 short glitch rejected, following frame intact
    cardLine = 1'b0;
    repeat (16) @(negedge clk);
    cardLine = 1'b1;
    repeat (3 * bitClk) @(negedge clk);
    check("R5 glitch no frame", rxFull, 0);
    cardSend(8'h5A, 1'b0, stopMid);
    waitFlag(rxFull, 200);
    check("R5 frame after glitch", rdData, 8'h5A);
    pulse(rdStrobe);
    pulse(irqRxClr);

    // R2/R3/R4 transmit frame, loop back into own receiver
    intCauseSel = 1'b1;
    writeByte(8'hB4);
    check("R3 txBufEmpty low after write", txBufEmpty, 0);
    waitLow(bitClk + 4, c);
    check("R3 start within one bit", (c <= bitClk + 3), 1);
    check("R3 buffer moved", txBufEmpty, 1);
    check("R3 shifting", txRegEmpty, 0);
    check("R4 no irq while shifting", irqTx, 0);
    txCapture(1'b0, fr);
    check("R2 frame bits", fr, {1'b1, ^8'hB4, 8'hB4, 1'b0});
    waitFlag(txRegEmpty, 200);
    repeat (2) @(negedge clk);
    check("R3 register empty", txRegEmpty, 1);
    check("R4 irq on empty", irqTx, 1);
    check("R8 no refusal", nackSeen, 0);
    waitFlag(rxFull, 200);
    check("R2 loopback data", rdData, 8'hB4);
    check("R2 loopback parity", parityErr, 0);
    pulse(rdStrobe);
    pulse(irqRxClr);
    pulse(irqTxClr);
    check("R4 irq cleared", irqTx, 0);

    // R4 cause 0: irq at transfer
    intCauseSel = 1'b0;
    writeByte(8'h0F);
    waitLow(bitClk + 4, c);
    check("R4 irq on transfer", irqTx, 1);
    txCapture(1'b0, fr);
    check("R2 frame 0x0F", fr, {1'b1, ^8'h0F, 8'h0F, 1'b0});
    waitFlag(txRegEmpty, 200);
    repeat (bitClk) @(negedge clk);
    pulse(rdStrobe);
    pulse(irqRxClr);
    pulse(irqTxClr);
    intCauseSel = 1'b1;

    // R8 far end refuses the byte
    writeByte(8'h33);
    txCapture(1'b1, fr);
    waitFlag(txRegEmpty, 200);
    repeat (bitClk) @(negedge clk);
    check("R8 refusal seen", nackSeen, 1);
    repeat (bitClk) @(negedge clk);
    check("R8 sticky", nackSeen, 1);
    pulse(nackClr);
    check("R8 cleared", nackSeen, 0);
    pulse(rdStrobe);
    pulse(irqRxClr);
    pulse(irqTxClr);

    // R9 transmit disabled holds the byte
    txEnable = 1'b0;
    writeByte(8'h77);
    for (int i = 0; i < 3 * bitClk; i++) begin
      @(negedge clk);
      if (lineOut !== 1'b1) begin check("R9 line idle while disabled", lineOut, 1); break; end
    end
    check("R9 byte held", txBufEmpty, 0);
    check("R9 not shifting", txRegEmpty, 1);
    txEnable = 1'b1;
    txCapture(1'b0, fr);
    check("R9 held byte sent", fr, {1'b1, ^8'h77, 8'h77, 1'b0});
    waitFlag(txRegEmpty, 200);
    repeat (bitClk) @(negedge clk);
    pulse(rdStrobe);
    pulse(irqRxClr);

    // R9 receive disabled
    rxEnable = 1'b0;
    cardSend(8'h99, 1'b0, stopMid);
    repeat (bitClk) @(negedge clk);
    check("R9 rx disabled", rxFull, 0);
    rxEnable = 1'b1;

    // R1 bit period with prescalers
    divSel = 2'd1; baudN = 8'd0;
    writeByte(8'hFF);
    waitLow(20000, c);
    c = 0;
    while (lineOut === 1'b0 && c < 5000) begin @(negedge clk); c++; end
    check("R1 /8 n=0 start width", c, 128);
    waitFlag(txRegEmpty, 20000);
    repeat (300) @(negedge clk);
    divSel = 2'd2; baudN = 8'd1;
    writeByte(8'hFF);
    waitLow(40000, c);
    c = 0;
    while (lineOut === 1'b0 && c < 5000) begin @(negedge clk); c++; end
    check("R1 /32 n=1 start width", c, 1024);
    waitFlag(txRegEmpty, 40000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule